// File: doc/BRIEF.md
# Timer and Watchdog with a Shared Prescaler

This block holds an 8-bit free-running timer and a watchdog counter that share one programmable prescaler. A 6-bit control register picks the timer's count source (the instruction-cycle tick or an external pin), which pin edge counts, which of the two counters owns the prescaler, and a 3-bit rate code. The rate code divides by a power of two. The same code gives twice the division when the timer owns the prescaler as when the watchdog owns it.

A host writes the timer or the control register through a one-word write port and reads the timer value on a dedicated output. Software keeps the watchdog from expiring by pulsing a clear strobe. The watchdog counts its own time-base tick and raises a one-cycle time-out pulse when it wraps. The timer raises a one-cycle overflow pulse when it wraps from all ones to zero.

Top module: `tick_timer_wdt`

## Requirements
- R1: After reset the timer reads 0, both pulses are low, and the control register is 0. A control value of 0 means internal source, rising edge, prescaler on the timer, and rate code 0. With that value the timer therefore advances once every 2 cycle ticks.
- R2: With control bit 5 = 0 and bit 3 = 1, the timer advances by exactly one on each cycle in which `cyc_tick` is high.
- R3: With control bit 5 = 1 and bit 4 = 0, each low-to-high transition of `ext_pin` advances the timer by one. Falling transitions and `cyc_tick` have no effect. The pin passes through a two-flop synchroniser first, so the timer changes at most by one per cycle.
- R4: With control bit 5 = 1 and bit 4 = 1, only high-to-low transitions of `ext_pin` advance the timer.
- R5: With control bit 3 = 0 and rate code r in bits 2:0, the timer advances once per 2^(r+1) source events (divide by 2 for code 0, up to 256 for code 7).
- R6: With control bit 3 = 1 and rate code r, the watchdog advances once per 2^r `wdt_tick` cycles (divide by 1 up to 128). With bit 3 = 0 it advances on every `wdt_tick`.
- R7: A write with `wr_addr` = 0 loads the timer from `wr_data`. A write with `wr_addr` = 1 loads the control register from `wr_data[5:0]`. Either write clears the prescaler, and timer source events in the two clock cycles after any write are ignored.
- R8: The timer wraps from 0xFF to 0x00, and `tmr_ovf` is high for exactly the one cycle in which the timer first reads 0x00 after the wrap.
- R9: Starting from a cleared watchdog and prescaler, `wdt_timeout` pulses for one cycle on the 2^WDT_W-th watchdog step, when the counter wraps to zero.
- R10: `wdt_clr` clears the watchdog counter. When control bit 3 = 1 it also clears the prescaler.
- R11: A timer write takes priority over an increment that falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_tick | input | 1 | Instruction-cycle tick, internal timer source |
| wdt_tick | input | 1 | Watchdog time-base tick |
| ext_pin | input | 1 | External count pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the timer, 1 the control register |
| wr_data | input | TMR_W | Write data |
| wdt_clr | input | 1 | Watchdog clear strobe |
| tmr_q | output | TMR_W | Current timer value |
| tmr_ovf | output | 1 | One-cycle timer wrap pulse |
| wdt_timeout | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The assertions assume single-cycle strobes and a timer that changes only by load or by one step. They also assume the pulses are judged only after the internal reset has been released. The bench drives every input just after a rising edge and holds the external pin steady for several cycles, so each level passes the synchroniser cleanly. It always leaves at least two idle cycles after a register write before it counts events. The watchdog is built with a 4-bit counter so that the rate codes can be swept to expiry in full.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int RATE_W = 3;
  localparam int CTL_W  = RATE_W + 3;

  typedef struct packed {
    logic              src_ext;
    logic              ext_fall;
    logic              psc_wdt;
    logic [RATE_W-1:0] rate;
  } ctl_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= 2'b00;
    else        sr <= {sr[0], 1'b1};
  end

  assign rst_n_s = sr[1];
endmodule

// File: rtl/pin_edge.sv
module pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q, sync_n;
  logic              prev_q;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/shared_psc.sv
module shared_psc
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              to_wdt,
  input  logic [RATE_W-1:0] rate,
  input  logic              tmr_evt,
  input  logic              wdt_evt,
  input  logic              clr,
  output logic              tmr_step,
  output logic              wdt_step
);
  localparam int PSC_W = 2 ** RATE_W;
  localparam int SH_W  = RATE_W + 1;

  logic [PSC_W-1:0] cnt_q, cnt_n, mask;
  logic [SH_W-1:0]  shamt;
  logic             in_evt, full, psc_step;

  assign shamt = to_wdt ? {1'b0, rate} : ({1'b0, rate} + SH_W'(1));

  for (genvar i = 0; i < PSC_W; i++) begin : g_mask
    assign mask[i] = (SH_W'(i) < shamt);
  end

  assign in_evt   = to_wdt ? wdt_evt : tmr_evt;
  assign full     = ((cnt_q & mask) == mask);
  assign psc_step = in_evt & full;
  assign tmr_step = to_wdt ? tmr_evt  : psc_step;
  assign wdt_step = to_wdt ? psc_step : wdt_evt;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)         cnt_n = '0;
    else if (in_evt) cnt_n = cnt_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  AST_TMR_STEP_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_step |-> tmr_evt);                                                   // R5
  AST_WDT_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_step |-> wdt_evt);                                                   // R6
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int TMR_W    = 8,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_tmr,
  input  logic             wr_any,
  input  logic [TMR_W-1:0] wr_data,
  input  logic             step,
  output logic [TMR_W-1:0] tmr_q,
  output logic             ovf_q,
  output logic             gate_open
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [TMR_W-1:0] tmr_n;
  logic             ovf_n;
  logic [HW-1:0]    hold_q, hold_n;

  always_comb begin
    tmr_n = tmr_q;
    ovf_n = 1'b0;
    if (wr_tmr) begin
      tmr_n = wr_data;
    end else if (step) begin
      tmr_n = tmr_q + TMR_W'(1);
      ovf_n = (tmr_q == {TMR_W{1'b1}});
    end
    if (wr_any)              hold_n = HW'(HOLD_CYC);
    else if (hold_q != '0)   hold_n = hold_q - HW'(1);
    else                     hold_n = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      ovf_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      tmr_q  <= tmr_n;
      ovf_q  <= ovf_n;
      hold_q <= hold_n;
    end
  end

  assign gate_open = (hold_q == '0);

  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (tmr_q == '0));                                                // R8
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tmr |=> (tmr_q == $past(wr_data)));                                   // R11
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_tmr |=> (tmr_q == $past(tmr_q) || tmr_q == $past(tmr_q) + TMR_W'(1))); // R3
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && !wr_tmr) |=> $stable(tmr_q));                             // R7
endmodule

// File: rtl/wdt_cnt.sv
module wdt_cnt #(
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clr,
  output logic timeout_q
);
  logic [WDT_W-1:0] cnt_q, cnt_n;
  logic             to_n;

  always_comb begin
    cnt_n = cnt_q;
    to_n  = 1'b0;
    if (clr) begin
      cnt_n = '0;
    end else if (step) begin
      cnt_n = cnt_q + WDT_W'(1);
      to_n  = (cnt_q == {WDT_W{1'b1}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      timeout_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      timeout_q <= to_n;
    end
  end

  AST_TIMEOUT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_q |-> (cnt_q == '0));                                            // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !timeout_q));                                    // R10
endmodule

// File: rtl/tick_timer_wdt.sv
module tick_timer_wdt
  import tmr_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int WDT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             wdt_tick,
  input  logic             ext_pin,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  input  logic             wdt_clr,
  output logic [TMR_W-1:0] tmr_q,
  output logic             tmr_ovf,
  output logic             wdt_timeout
);
  logic rst_i;
  ctl_t ctl_q, ctl_n;
  logic wr_tmr, wr_ctl, ext_rise, ext_fall;
  logic src_evt, gated_evt, gate_open, psc_clr;
  logic tmr_step, wdt_step;

  rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_i));

  assign wr_tmr = wr_en & ~wr_addr;
  assign wr_ctl = wr_en &  wr_addr;

  always_comb begin
    ctl_n = ctl_q;
    if (wr_ctl) ctl_n = ctl_t'(wr_data[CTL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) ctl_q <= '0;
    else        ctl_q <= ctl_n;
  end

  pin_edge #(.STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_i), .pin(ext_pin), .rise(ext_rise), .fall(ext_fall)
  );

  assign src_evt   = ctl_q.src_ext ? (ctl_q.ext_fall ? ext_fall : ext_rise) : cyc_tick;
  assign gated_evt = src_evt & gate_open;
  assign psc_clr   = wr_en | (wdt_clr & ctl_q.psc_wdt);

  shared_psc u_psc (
    .clk(clk), .rst_n(rst_i), .to_wdt(ctl_q.psc_wdt), .rate(ctl_q.rate),
    .tmr_evt(gated_evt), .wdt_evt(wdt_tick), .clr(psc_clr),
    .tmr_step(tmr_step), .wdt_step(wdt_step)
  );

  tmr_core #(.TMR_W(TMR_W), .HOLD_CYC(2)) u_tmr (
    .clk(clk), .rst_n(rst_i), .wr_tmr(wr_tmr), .wr_any(wr_en), .wr_data(wr_data),
    .step(tmr_step), .tmr_q(tmr_q), .ovf_q(tmr_ovf), .gate_open(gate_open)
  );

  wdt_cnt #(.WDT_W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_i), .step(wdt_step), .clr(wdt_clr), .timeout_q(wdt_timeout)
  );

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_i)
    wr_ctl |=> (ctl_q == ctl_t'($past(wr_data[CTL_W-1:0]))));                // R7
  AST_EDGE_SELECT: assert property (@(posedge clk) disable iff (!rst_i)
    (ctl_q.src_ext && !ctl_q.psc_wdt && tmr_step) |-> (ctl_q.ext_fall ? ext_fall : ext_rise)); // R4
endmodule

// File: tb/sim_tick_timer_wdt.sv
module sim_tick_timer_wdt;
  logic       clk = 1'b0;
  logic       rst_n, cyc_tick, wdt_tick, ext_pin, wr_en, wr_addr, wdt_clr;
  logic [7:0] wr_data, tmr_q;
  logic       tmr_ovf, wdt_timeout;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  tick_timer_wdt #(.TMR_W(8), .WDT_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .wdt_tick(wdt_tick),
    .ext_pin(ext_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wdt_clr(wdt_clr), .tmr_q(tmr_q), .tmr_ovf(tmr_ovf), .wdt_timeout(wdt_timeout)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    cyc_tick = 1'b1;
    cyc(n);
    cyc_tick = 1'b0;
  endtask

  task automatic wclr();
    wdt_clr = 1'b1;
    cyc(1);
    wdt_clr = 1'b0;
  endtask

  task automatic wdt_run(input int limit, output int first);
    first = -1;
    for (int i = 1; i <= limit && first < 0; i++) begin
      wdt_tick = 1'b1;
      cyc(1);
      if (wdt_timeout) first = i;
    end
    wdt_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int first, base;
    rst_n = 1'b0; cyc_tick = 1'b0; wdt_tick = 1'b0; ext_pin = 1'b0;
    wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00; wdt_clr = 1'b0;
    cyc(3);
    #1 rst_n = 1'b1;
    cyc(4);

    // R1 reset state and default control value
    chk("R1 tmr", tmr_q, 0);
    chk("R1 ovf", tmr_ovf, 0);
    chk("R1 timeout", wdt_timeout, 0);
    ticks(4);
    chk("R1 default divide by 2", tmr_q, 2);

    // R2 internal source, prescaler on watchdog
    wr(1'b1, 8'h0B);
    wr(1'b0, 8'h00);
    cyc(2);
    for (int i = 0; i < 10; i++) begin ticks(1); cyc(i % 3); end
    chk("R2 one per tick", tmr_q, 10);

    // R7 and R11 write priority and two-cycle hold
    wr(1'b1, 8'h08);
    cyc(2);
    cyc_tick = 1'b1;
    wr(1'b0, 8'h10);
    chk("R11 write wins", tmr_q, 8'h10);
    cyc(1); chk("R7 hold cycle 1", tmr_q, 8'h10);
    cyc(1); chk("R7 hold cycle 2", tmr_q, 8'h10);
    cyc(1); chk("R7 hold released", tmr_q, 8'h11);
    cyc_tick = 1'b0;

    // R3 rising edges counted, falling ignored, cycle ticks ignored
    wr(1'b1, 8'h28);
    wr(1'b0, 8'h00);
    cyc(2);
    cyc_tick = 1'b1;
    ext_pin = 1'b1; cyc(5);
    chk("R3 rise counted", tmr_q, 1);
    ext_pin = 1'b0; cyc(5);
    chk("R3 fall ignored", tmr_q, 1);
    for (int i = 0; i < 4; i++) begin ext_pin = 1'b1; cyc(4); ext_pin = 1'b0; cyc(4); end
    cyc(3);
    chk("R3 five rises", tmr_q, 5);
    cyc_tick = 1'b0;

    // R4 falling edges only
    wr(1'b1, 8'h38);
    wr(1'b0, 8'h00);
    cyc(2);
    ext_pin = 1'b1; cyc(5);
    chk("R4 rise ignored", tmr_q, 0);
    ext_pin = 1'b0; cyc(5);
    chk("R4 fall counted", tmr_q, 1);
    for (int i = 0; i < 3; i++) begin ext_pin = 1'b1; cyc(4); ext_pin = 1'b0; cyc(4); end
    cyc(3);
    chk("R4 four falls", tmr_q, 4);

    // R5 timer prescale sweep over all rate codes
    for (int r = 0; r < 8; r++) begin
      wr(1'b1, 8'(r));
      wr(1'b0, 8'h00);
      cyc(2);
      ticks(3 * (2 << r) - 1);
      chk($sformatf("R5 rate %0d before step", r), tmr_q, 2);
      ticks(1);
      chk($sformatf("R5 rate %0d at step", r), tmr_q, 3);
    end

    // R7 control write clears the prescaler
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h00);
    cyc(2);
    ticks(5);
    wr(1'b1, 8'h02);
    cyc(2);
    ticks(7);
    chk("R7 prescaler cleared", tmr_q, 0);
    ticks(1);
    chk("R7 eighth event steps", tmr_q, 1);

    // R8 wrap and overflow pulse
    wr(1'b1, 8'h08);
    wr(1'b0, 8'hFD);
    cyc(2);
    ticks(1); chk("R8 FE", tmr_q, 8'hFE); chk("R8 no ovf at FE", tmr_ovf, 0);
    ticks(1); chk("R8 FF", tmr_q, 8'hFF); chk("R8 no ovf at FF", tmr_ovf, 0);
    ticks(1); chk("R8 wrap to 0", tmr_q, 0); chk("R8 ovf high", tmr_ovf, 1);
    cyc(1);   chk("R8 ovf one cycle", tmr_ovf, 0);

    // R6 and R9 watchdog expiry for every rate with the prescaler on it
    for (int r = 0; r < 8; r++) begin
      wr(1'b1, 8'h08 | 8'(r));
      wclr();
      wdt_run(5000, first);
      chk($sformatf("R9 rate %0d expiry tick", r), first, 16 << r);
      cyc(1);
      chk($sformatf("R9 rate %0d pulse width", r), wdt_timeout, 0);
    end

    // R6 prescaler on the timer: watchdog steps on every tick
    wr(1'b1, 8'h07);
    wclr();
    wdt_run(5000, first);
    chk("R6 undivided watchdog", first, 16);

    // R10 clear strobe resets counter and prescaler
    wr(1'b1, 8'h09);
    wclr();
    base = 0;
    for (int i = 0; i < 21; i++) begin wdt_tick = 1'b1; cyc(1); base += int'(wdt_timeout); end
    wdt_tick = 1'b0;
    chk("R10 no early expiry", base, 0);
    wclr();
    wdt_run(5000, first);
    chk("R10 full period after clear", first, 32);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule